// File: doc/BRIEF.md
# Autoscan Conversion Request Sequencer

This block feeds an analog-to-digital converter with conversion requests drawn from a set of eight channels. Two masks drive it. A channel-select mask names the channels of interest. A pending mask lists the channels that still await conversion. A load event moves the select mask into the pending mask. The load event can come from a software command, from an edge on an external trigger pin, or from the block itself when autoscan is on.

While the gate condition permits, the sequencer picks the lowest-numbered pending channel. It raises a one-cycle start pulse with that channel number and then waits. The converter answers with done, which retires the channel, or with cancel. Depending on the repeat policy, a cancelled channel stays pending for a retry or is dropped.

A 32-bit control word selects the gate mode, the trigger enable, the source interrupt, autoscan, the load mode and the repeat policy. The same word carries two command bits that act only when written. When the last pending conversion completes, the block can raise a one-cycle interrupt and, in autoscan mode, reload the pending mask so the scan repeats.

Top module: `adc_scan_source`

## Requirements
- R1: After reset the control readback, the select mask and the pending mask are all zero, and neither conv_start nor src_irq is asserted.
- R2: Control readback places the gate mode at [1:0], trigger enable at 2, interrupt enable at 3, autoscan at 4, load mode at 5 and repeat-disable at 16. Bits 8 and 9 always read 0. Bit 7 shows the gate_in level delayed by a two-flop synchronizer. Every other bit reads 0. A written field takes effect from the next clock, so a command in the same write acts under the previous settings.
- R3: With load mode 0 (overwrite), a load event (for example writing 1 to command bit 9) replaces the pending mask with the select mask. Writing 0 to bit 9 does nothing.
- R4: With load mode 1 (combine), a load event ORs the select mask into the pending mask.
- R5: Writing 1 to command bit 8 clears every pending bit. When a clear and a load fall on the same cycle, the clear is applied first, so the pending mask ends equal to the select mask.
- R6: Gate mode 0 issues no requests. Mode 1 issues requests whenever any bit is pending. Mode 2 also requires the synchronized gate level to be high. Mode 3 also requires it to be low.
- R7: Requests go out lowest channel first. Each is a one-cycle conv_start pulse with conv_chan holding the channel number. Only one request is outstanding until conv_done or conv_cancel arrives.
- R8: conv_done clears the pending bit of the channel in conversion.
- R9: On conv_cancel with repeat-disable 0, the channel stays pending and is requested again. With repeat-disable 1, its pending bit is cleared.
- R10: With trigger enable set, the edge of trig_in selected by trig_fall (0 rising, 1 falling) makes a load event three clocks after the pin changes (two synchronizer flops plus one edge flop). With trigger enable clear, trig_in has no effect.
- R11: With interrupt enable set, src_irq pulses for one cycle after a conv_done that leaves no other channel pending.
- R12: With autoscan set, that same completion event also produces a load event, so the scan restarts without software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_rdata | output | 32 | Control word readback |
| sel_wr | input | 1 | Select mask write strobe |
| sel_wdata | input | 8 | Select mask write data |
| sel_rdata | output | 8 | Select mask readback |
| pend_rdata | output | 8 | Pending mask readback |
| gate_in | input | 1 | Asynchronous gate level |
| trig_in | input | 1 | Asynchronous trigger pin |
| trig_fall | input | 1 | Trigger edge select: 0 rising, 1 falling |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 3 | Channel of the current request |
| conv_done | input | 1 | Converter completed the request |
| conv_cancel | input | 1 | Converter aborted the request |
| src_irq | output | 1 | One-cycle source interrupt |

## Verification
The assertions assume a well-behaved converter. It pulses conv_done or conv_cancel only while a request is outstanding, and never both in the same cycle. The bench's converter responder keeps to this rule: it answers only when its model shows a request in flight, and it raises exactly one response for one cycle. Configuration inputs and the trigger-edge select are changed only while the trigger level is steady, so no spurious edge is produced.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  localparam int CFG_W  = 32;
  localparam int B_GATE = 0;
  localparam int B_TRIG = 2;
  localparam int B_IRQ  = 3;
  localparam int B_SCAN = 4;
  localparam int B_LDM  = 5;
  localparam int B_LVL  = 7;
  localparam int B_CLR  = 8;
  localparam int B_LOAD = 9;
  localparam int B_RPT  = 16;

  typedef enum logic [1:0] {
    GATE_OFF  = 2'd0,
    GATE_ANY  = 2'd1,
    GATE_HIGH = 2'd2,
    GATE_LOW  = 2'd3
  } gate_mode_e;

  typedef struct packed {
    logic       rpt_dis;
    logic       ld_or;
    logic       autoscan;
    logic       irq_en;
    logic       trig_en;
    gate_mode_e gate;
  } scan_cfg_t;

endpackage

// File: rtl/scan_sync.sv
module scan_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  assign sh_d = {sh_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/scan_edge.sv
module scan_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  input  logic fall_sel,
  output logic pulse
);
  logic d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_q <= 1'b0;
    else        d_q <= d;
  end

  always_comb begin
    if (fall_sel) pulse = d_q & ~d;
    else          pulse = ~d_q & d;
  end
endmodule

// File: rtl/scan_cfg_reg.sv
module scan_cfg_reg
  import adc_scan_pkg::*;
#(
  parameter int DW = CFG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          gate_lvl,
  output scan_cfg_t     cfg,
  output logic          clr_cmd,
  output logic          load_cmd,
  output logic [DW-1:0] rdata
);
  scan_cfg_t cfg_q;
  scan_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d.gate     = gate_mode_e'(wdata[B_GATE +: 2]);
      cfg_d.trig_en  = wdata[B_TRIG];
      cfg_d.irq_en   = wdata[B_IRQ];
      cfg_d.autoscan = wdata[B_SCAN];
      cfg_d.ld_or    = wdata[B_LDM];
      cfg_d.rpt_dis  = wdata[B_RPT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign clr_cmd  = wr_en & wdata[B_CLR];
  assign load_cmd = wr_en & wdata[B_LOAD];
  assign cfg      = cfg_q;

  always_comb begin
    rdata               = '0;
    rdata[B_GATE +: 2]  = cfg_q.gate;
    rdata[B_TRIG]       = cfg_q.trig_en;
    rdata[B_IRQ]        = cfg_q.irq_en;
    rdata[B_SCAN]       = cfg_q.autoscan;
    rdata[B_LDM]        = cfg_q.ld_or;
    rdata[B_LVL]        = gate_lvl;
    rdata[B_RPT]        = cfg_q.rpt_dis;
  end
endmodule

// File: rtl/scan_pend_arb.sv
module scan_pend_arb
  import adc_scan_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  scan_cfg_t      cfg,
  input  logic [NCH-1:0] sel,
  input  logic           gate_lvl,
  input  logic           clr_cmd,
  input  logic           ext_load,
  input  logic           conv_done,
  input  logic           conv_cancel,
  output logic [NCH-1:0] pend,
  output logic           conv_start,
  output logic [CW-1:0]  conv_chan,
  output logic           src_irq
);
  typedef enum logic {ST_IDLE, ST_BUSY} arb_state_e;

  arb_state_e     state_q, state_d;
  logic [NCH-1:0] pend_q, pend_d;
  logic [CW-1:0]  act_q, act_d;
  logic           start_q, start_d;
  logic           irq_q, irq_d;

  logic           gate_ok;
  logic [CW-1:0]  pick;
  logic [NCH-1:0] act_oh;
  logic           busy;
  logic           src_evt;
  logic           load_evt;
  logic           retire;

  always_comb begin
    unique case (cfg.gate)
      GATE_OFF:  gate_ok = 1'b0;
      GATE_ANY:  gate_ok = 1'b1;
      GATE_HIGH: gate_ok = gate_lvl;
      default:   gate_ok = ~gate_lvl;
    endcase
  end

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_q[i]) pick = CW'(i);
    end
  end

  assign busy     = (state_q == ST_BUSY);
  assign act_oh   = NCH'(1) << act_q;
  assign src_evt  = busy & conv_done & ((pend_q & ~act_oh) == '0);
  assign load_evt = ext_load | (cfg.autoscan & src_evt);
  assign retire   = busy & (conv_done | (conv_cancel & cfg.rpt_dis));

  always_comb begin
    pend_d = pend_q;
    if (clr_cmd) pend_d = '0;
    if (retire)  pend_d = pend_d & ~act_oh;
    if (load_evt) begin
      if (cfg.ld_or) pend_d = pend_d | sel;
      else           pend_d = sel;
    end
  end

  always_comb begin
    state_d = state_q;
    act_d   = act_q;
    start_d = 1'b0;
    if (busy) begin
      if (conv_done || conv_cancel) state_d = ST_IDLE;
    end else if (gate_ok && (pend_q != '0)) begin
      state_d = ST_BUSY;
      act_d   = pick;
      start_d = 1'b1;
    end
    irq_d = cfg.irq_en & src_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      act_q   <= '0;
      start_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      act_q   <= act_d;
      start_q <= start_d;
      irq_q   <= irq_d;
    end
  end

  assign pend       = pend_q;
  assign conv_start = start_q;
  assign conv_chan  = act_q;
  assign src_irq    = irq_q;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R7
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done && !conv_cancel) |=> !conv_start); // R7
  AST_RESP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done || conv_cancel) |-> (busy && !(conv_done && conv_cancel))); // R7
  AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_ok |=> !conv_start); // R6
  AST_GATE_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && gate_ok && (pend_q != '0)) |=> conv_start); // R6
  AST_DONE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && conv_done && !load_evt) |=> ((pend_q & $past(act_oh)) == '0)); // R8
  AST_CANCEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && conv_cancel && !cfg.rpt_dis && !clr_cmd && !(load_evt && !cfg.ld_or))
    |=> ((pend_q & $past(act_oh)) == ($past(pend_q) & $past(act_oh)))); // R9
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd && !load_evt) |=> (pend_q == '0)); // R5
  AST_COMBINE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && cfg.ld_or && !clr_cmd) |=> ((pend_q & $past(sel)) == $past(sel))); // R4
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    src_irq |=> !src_irq); // R11
endmodule

// File: rtl/adc_scan_source.sv
module adc_scan_source
  import adc_scan_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int DW   = CFG_W,
  parameter int SYNC = 2,
  localparam int CW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctrl_wr,
  input  logic [DW-1:0]  ctrl_wdata,
  output logic [DW-1:0]  ctrl_rdata,
  input  logic           sel_wr,
  input  logic [NCH-1:0] sel_wdata,
  output logic [NCH-1:0] sel_rdata,
  output logic [NCH-1:0] pend_rdata,
  input  logic           gate_in,
  input  logic           trig_in,
  input  logic           trig_fall,
  output logic           conv_start,
  output logic [CW-1:0]  conv_chan,
  input  logic           conv_done,
  input  logic           conv_cancel,
  output logic           src_irq
);
  logic [1:0]     rst_sh_q;
  logic           rst_sync_n;
  logic [NCH-1:0] sel_q, sel_d;
  logic           gate_lvl;
  logic           trig_lvl;
  logic           trig_edge;
  scan_cfg_t      cfg;
  logic           clr_cmd;
  logic           load_cmd;
  logic           ext_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sh_q[1];

  always_comb begin
    sel_d = sel_q;
    if (sel_wr) sel_d = sel_wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sel_q <= '0;
    else             sel_q <= sel_d;
  end
  assign sel_rdata = sel_q;

  scan_sync #(.STAGES(SYNC)) i_gate_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(gate_in), .q(gate_lvl)
  );

  scan_sync #(.STAGES(SYNC)) i_trig_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(trig_in), .q(trig_lvl)
  );

  scan_edge i_trig_edge (
    .clk(clk), .rst_n(rst_sync_n), .d(trig_lvl), .fall_sel(trig_fall),
    .pulse(trig_edge)
  );

  scan_cfg_reg #(.DW(DW)) i_cfg (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(ctrl_wr), .wdata(ctrl_wdata),
    .gate_lvl(gate_lvl), .cfg(cfg), .clr_cmd(clr_cmd), .load_cmd(load_cmd),
    .rdata(ctrl_rdata)
  );

  assign ext_load = load_cmd | (cfg.trig_en & trig_edge);

  scan_pend_arb #(.NCH(NCH)) i_arb (
    .clk(clk), .rst_n(rst_sync_n), .cfg(cfg), .sel(sel_q),
    .gate_lvl(gate_lvl), .clr_cmd(clr_cmd), .ext_load(ext_load),
    .conv_done(conv_done), .conv_cancel(conv_cancel),
    .pend(pend_rdata), .conv_start(conv_start), .conv_chan(conv_chan),
    .src_irq(src_irq)
  );

  AST_TRIG_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cfg.trig_en && !load_cmd && !clr_cmd && !conv_done && !conv_cancel)
    |=> $stable(pend_rdata)); // R10
endmodule

// File: tb/test_adc_scan_source.sv
module test_adc_scan_source;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [31:0] ctrl_rdata;
  logic        sel_wr = 1'b0;
  logic [7:0]  sel_wdata = '0;
  logic [7:0]  sel_rdata;
  logic [7:0]  pend_rdata;
  logic        gate_in = 1'b0;
  logic        trig_in = 1'b0;
  logic        trig_fall = 1'b0;
  logic        conv_start;
  logic [2:0]  conv_chan;
  logic        conv_done = 1'b0;
  logic        conv_cancel = 1'b0;
  logic        src_irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n_starts = 0;
  int n_irq = 0;
  int resp_lat = 2;
  int rcnt = 0;
  bit cancel_next = 1'b0;
  bit first_chk_done = 1'b0;

  // reference model state
  logic       m_rs1 = 0, m_rs2 = 0;
  logic [1:0] m_mode = 0;
  logic       m_trg = 0, m_ensi = 0, m_scan = 0, m_ldm = 0, m_rpt = 0;
  logic [7:0] m_sel = 0, m_pend = 0;
  logic       m_busy = 0, m_start = 0, m_irq = 0;
  logic [2:0] m_act = 0;
  logic       m_g1 = 0, m_g2 = 0, m_t1 = 0, m_t2 = 0, m_t3 = 0;

  adc_scan_source i_adc_scan_source (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .sel_rdata(sel_rdata), .pend_rdata(pend_rdata), .gate_in(gate_in),
    .trig_in(trig_in), .trig_fall(trig_fall), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_done(conv_done), .conv_cancel(conv_cancel),
    .src_irq(src_irq)
  );

  always #10 clk = ~clk;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act 0x%0h exp 0x%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] cw(int mode, bit trg, bit irq, bit scan,
                                     bit ldm, bit rpt, bit clr, bit ld);
    logic [31:0] w = '0;
    w[1:0] = mode[1:0];
    w[2] = trg; w[3] = irq; w[4] = scan; w[5] = ldm;
    w[8] = clr; w[9] = ld; w[16] = rpt;
    return w;
  endfunction

  // cycle model, then comparison just after the edge
  always @(posedge clk) begin : model
    logic [7:0] p;
    logic gok, edge_v, src, ld;
    int low;
    cyc++;
    if (m_rs2) begin
      edge_v = trig_fall ? (m_t3 & !m_t2) : (!m_t3 & m_t2);
      case (m_mode)
        2'd0: gok = 1'b0;
        2'd1: gok = 1'b1;
        2'd2: gok = m_g2;
        default: gok = !m_g2;
      endcase
      src = m_busy && conv_done && ((m_pend & ~(8'd1 << m_act)) == 8'd0);
      ld = (ctrl_wr && ctrl_wdata[9]) || (m_trg && edge_v) || (m_scan && src);
      p = m_pend;
      if (ctrl_wr && ctrl_wdata[8]) p = 8'd0;
      if (m_busy && (conv_done || (conv_cancel && m_rpt))) p[m_act] = 1'b0;
      if (ld) p = m_ldm ? (p | m_sel) : m_sel;
      m_irq = m_ensi && src;
      m_start = 1'b0;
      if (m_busy) begin
        if (conv_done || conv_cancel) m_busy = 1'b0;
      end else if (gok && m_pend != 8'd0) begin
        low = 0;
        for (int i = 7; i >= 0; i--) if (m_pend[i]) low = i;
        m_busy = 1'b1;
        m_act = 3'(low);
        m_start = 1'b1;
      end
      m_pend = p;
      if (ctrl_wr) begin
        m_mode = ctrl_wdata[1:0]; m_trg = ctrl_wdata[2]; m_ensi = ctrl_wdata[3];
        m_scan = ctrl_wdata[4]; m_ldm = ctrl_wdata[5]; m_rpt = ctrl_wdata[16];
      end
      if (sel_wr) m_sel = sel_wdata;
      m_t3 = m_t2; m_t2 = m_t1; m_t1 = trig_in;
      m_g2 = m_g1; m_g1 = gate_in;
    end
    if (!rst_n) begin m_rs1 = 0; m_rs2 = 0; end
    else begin m_rs2 = m_rs1; m_rs1 = 1'b1; end
    #2;
    chk("R2", "ctrl_rdata", ctrl_rdata,
        {15'd0, m_rpt, 8'd0, m_g2, 1'b0, m_ldm, m_scan, m_ensi, m_trg, m_mode});
    chk("R3", "sel_rdata", sel_rdata, m_sel);
    chk("R3", "pend_rdata", pend_rdata, m_pend);
    chk("R7", "conv_start", conv_start, m_start);
    chk("R7", "conv_chan", conv_chan, m_act);
    chk("R11", "src_irq", src_irq, m_irq);
    if (conv_start) n_starts++;
    if (src_irq) n_irq++;
  end

  // converter responder
  always @(negedge clk) begin
    if (conv_done || conv_cancel) begin
      conv_done <= 1'b0; conv_cancel <= 1'b0; rcnt = 0;
    end else if (m_busy) begin
      if (rcnt >= resp_lat) begin
        if (cancel_next) begin conv_cancel <= 1'b1; cancel_next = 1'b0; end
        else conv_done <= 1'b1;
      end else rcnt++;
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog act %0d exp below 100000 cycles", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(logic [31:0] d);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = d;
    @(negedge clk); ctrl_wr = 1'b0; ctrl_wdata = '0;
  endtask

  task automatic wr_sel(logic [7:0] d);
    @(negedge clk); sel_wr = 1'b1; sel_wdata = d;
    @(negedge clk); sel_wr = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (m_pend == 8'd0 && !m_busy) break;
    end
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (!m_busy) break;
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    chk("R1", "ctrl after reset", ctrl_rdata, 0);
    chk("R1", "pend after reset", pend_rdata, 0);
    chk("R1", "start/irq after reset", {conv_start, src_irq}, 0);

    // R2 readback with command bits set
    wr_ctrl(32'h0001_033F);
    chk("R2", "ctrl readback", ctrl_rdata, 32'h0001_003F);
    gate_in = 1'b1; idle(3);
    chk("R2", "gate level bit", ctrl_rdata[7], 1);
    gate_in = 1'b0; wr_ctrl(32'd0); idle(3);

    // R3 overwrite load
    wr_sel(8'hA5);
    wr_ctrl(cw(0, 0, 0, 0, 0, 0, 0, 1));
    chk("R3", "overwrite load", pend_rdata, 8'hA5);
    wr_ctrl(cw(0, 0, 0, 0, 0, 0, 0, 0));
    chk("R3", "bit9 zero no load", pend_rdata, 8'hA5);

    // R4 combine load
    wr_sel(8'h0F);
    wr_ctrl(cw(0, 0, 0, 0, 1, 0, 0, 0));
    wr_ctrl(cw(0, 0, 0, 0, 1, 0, 0, 1));
    chk("R4", "combine load", pend_rdata, 8'hAF);

    // R5 clear, then clear plus load
    wr_ctrl(cw(0, 0, 0, 0, 1, 0, 1, 0));
    chk("R5", "clear pending", pend_rdata, 8'h00);
    wr_ctrl(cw(0, 0, 0, 0, 1, 0, 0, 1));
    wr_ctrl(cw(0, 0, 0, 0, 1, 0, 1, 1));
    chk("R5", "clear before load", pend_rdata, 8'h0F);
    wr_ctrl(cw(0, 0, 0, 0, 0, 0, 1, 0));

    // R7/R8 mode 1, lowest first
    wr_sel(8'h96);
    wr_ctrl(cw(0, 0, 0, 0, 0, 0, 0, 1));
    idle(5);
    chk("R6", "mode 0 holds pending", pend_rdata, 8'h96);
    wr_ctrl(cw(1, 0, 0, 0, 0, 0, 0, 0));
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (conv_start) begin
        chk("R7", "first channel", conv_chan, 1);
        first_chk_done = 1'b1;
        break;
      end
    end
    chk("R7", "start seen", first_chk_done, 1);
    drain();
    chk("R8", "all retired", pend_rdata, 0);

    // R6 mode 2
    wr_ctrl(cw(0, 0, 0, 0, 0, 0, 0, 0));
    wr_sel(8'h81);
    wr_ctrl(cw(2, 0, 0, 0, 0, 0, 0, 1));
    idle(10);
    chk("R6", "mode 2 gate low blocks", pend_rdata, 8'h81);
    gate_in = 1'b1;
    drain();
    chk("R6", "mode 2 gate high runs", pend_rdata, 0);

    // R6 mode 3
    wr_sel(8'h40);
    wr_ctrl(cw(3, 0, 0, 0, 0, 0, 0, 1));
    idle(10);
    chk("R6", "mode 3 gate high blocks", pend_rdata, 8'h40);
    gate_in = 1'b0;
    drain();
    chk("R6", "mode 3 gate low runs", pend_rdata, 0);

    // R9 cancel with repeat
    wr_ctrl(cw(0, 0, 0, 0, 0, 0, 0, 0));
    wr_sel(8'h04);
    wr_ctrl(cw(0, 0, 0, 0, 0, 0, 0, 1));
    cancel_next = 1'b1;
    n_starts = 0;
    wr_ctrl(cw(1, 0, 0, 0, 0, 0, 0, 0));
    drain();
    chk("R9", "cancel retried", n_starts, 2);
    // R9 cancel with discard
    wr_ctrl(cw(0, 0, 0, 0, 0, 1, 0, 1));
    cancel_next = 1'b1;
    n_starts = 0;
    wr_ctrl(cw(1, 0, 0, 0, 0, 1, 0, 0));
    drain();
    chk("R9", "cancel discarded", n_starts, 1);
    chk("R9", "discard pending", pend_rdata, 0);

    // R10 trigger
    wr_ctrl(cw(0, 0, 0, 0, 0, 0, 0, 0));
    wr_sel(8'h30);
    trig_in = 1'b1; idle(6); trig_in = 1'b0; idle(6);
    chk("R10", "trigger disabled ignored", pend_rdata, 0);
    wr_ctrl(cw(0, 1, 0, 0, 0, 0, 0, 0));
    trig_in = 1'b1; idle(2);
    chk("R10", "before sync latency", pend_rdata, 0);
    idle(4);
    chk("R10", "rising edge loads", pend_rdata, 8'h30);
    wr_ctrl(cw(0, 1, 0, 0, 0, 0, 1, 0));
    trig_in = 1'b0; idle(6);
    chk("R10", "falling not selected", pend_rdata, 0);
    trig_fall = 1'b1; idle(2);
    trig_in = 1'b1; idle(6);
    chk("R10", "rising not selected", pend_rdata, 0);
    trig_in = 1'b0; idle(6);
    chk("R10", "falling edge loads", pend_rdata, 8'h30);
    wr_ctrl(cw(0, 0, 0, 0, 0, 0, 1, 0));

    // R11 interrupt
    wr_sel(8'h03);
    wr_ctrl(cw(0, 0, 1, 0, 0, 0, 0, 1));
    n_irq = 0;
    wr_ctrl(cw(1, 0, 1, 0, 0, 0, 0, 0));
    drain();
    idle(2);
    chk("R11", "one irq per scan", n_irq, 1);

    // R12 autoscan
    n_irq = 0;
    wr_ctrl(cw(1, 0, 1, 1, 0, 0, 0, 1));
    idle(80);
    chk("R12", "autoscan repeats", (n_irq >= 3) ? 1 : 0, 1);
    wr_ctrl(cw(0, 0, 0, 0, 0, 0, 0, 0));
    wait_idle();
    wr_ctrl(cw(0, 0, 0, 0, 0, 0, 1, 0));
    idle(3);
    chk("R5", "final clear", pend_rdata, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule